// File: doc/BRIEF.md
# Masked Multi-Source Interrupt Selector

The selector gathers eight single-cycle event pulses into one interrupt request line. Each source owns a sticky event flag and an enable bit. A flag is set by its event whether or not the source is enabled. The request line is raised when at least one flag has its enable bit set. The service routine reads the flag byte to tell which source fired. It can also poll the flags for events that raised no request.

Software sees one 16-bit register. The upper byte holds the enables and the lower byte holds the flags. A configuration write updates only the enables. The flags are changed by a write-one-to-clear port. A separate set port, meant for test, can force flags. The event inputs are plain wires, so one event can feed several selector instances. Each instance has its own mask and its own request line.

Top module: `evt_irq_sel`

## Requirements
- R1: After reset, all enables, all flags and the request output are zero.
- R2: An event pulse on source i sets flag i (read data bit i) at the next clock edge, whatever the value of enable i.
- R3: A flag that has been set stays set until it is cleared. Later cycles with no event leave it unchanged.
- R4: A clear-port write with data bit i at one clears flag i at the next edge. Flags whose clear data bit is zero are kept.
- R5: If an event on source i or a set-port bit i arrives in the same cycle as a clear of bit i, the flag ends up set.
- R6: A configuration write loads data bits 15:8 into the enables (read data bits 15:8). Data bits 7:0 of that write are ignored, and the flags are left unchanged.
- R7: A set-port write with data bit i at one sets flag i at the next edge.
- R8: The request output is registered. In each cycle it equals the OR, over all sources, of flag AND enable as they stood one cycle earlier.
- R9: A flag whose enable is zero raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | 8 | Single-cycle event pulses, one per source |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration data; upper byte is the enables, lower byte is ignored |
| clr_we_i | input | 1 | Clear-port write strobe |
| clr_wdata_i | input | 8 | Write-one-to-clear flag mask |
| set_we_i | input | 1 | Set-port write strobe |
| set_wdata_i | input | 8 | Write-one-to-set flag mask |
| reg_rdata_o | output | 16 | Register read value: enables in 15:8, flags in 7:0 |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Events are first applied with every enable off. This separates flag latching from request generation. Next, a configuration write with ones in its lower byte changes only the enables, and the request must follow one cycle later. Directed cycles then place a clear on the same bit as an event and on the same bit as a set, which exposes the tie-break in the wrong direction. A long run of random events, clears, sets and enable writes, compared on every clock against a behavioural model, covers the mixed cases.

// File: rtl/evt_irq_sel.sv
module evt_irq_sel #(
  parameter int N = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   event_i,
  input  logic           cfg_we_i,
  input  logic [2*N-1:0] cfg_wdata_i,
  input  logic           clr_we_i,
  input  logic [N-1:0]   clr_wdata_i,
  input  logic           set_we_i,
  input  logic [N-1:0]   set_wdata_i,
  output logic [2*N-1:0] reg_rdata_o,
  output logic           irq_o
);
  logic [N-1:0] en_q, flag_q, clr_m, set_m;

  assign clr_m = clr_we_i ? clr_wdata_i : '0;
  assign set_m = (set_we_i ? set_wdata_i : '0) | event_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      flag_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (cfg_we_i) en_q <= cfg_wdata_i[2*N-1:N];
      flag_q <= (flag_q & ~clr_m) | set_m;
      irq_o  <= |(flag_q & en_q);
    end
  end

  assign reg_rdata_o = {en_q, flag_q};
endmodule

module evt_irq_sel_chk #(
  parameter int N = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [N-1:0]   event_i,
  input logic           cfg_we_i,
  input logic           clr_we_i,
  input logic [N-1:0]   clr_wdata_i,
  input logic           set_we_i,
  input logic [N-1:0]   set_wdata_i,
  input logic [2*N-1:0] reg_rdata_o,
  input logic           irq_o
);
  logic [N-1:0] flags, ens;
  assign flags = reg_rdata_o[N-1:0];
  assign ens   = reg_rdata_o[2*N-1:N];

  a_r2_r5_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i != '0) |=> ((flags & $past(event_i)) == $past(event_i)));

  a_r7_set_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((flags & $past(set_wdata_i)) == $past(set_wdata_i)));

  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !set_we_i) |=> ((flags & $past(clr_wdata_i & ~event_i)) == '0));

  a_r6_flags_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !clr_we_i && !set_we_i && event_i == '0) |=> $stable(flags));

  a_r8_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(flags & ens) |=> (irq_o == (|$past(flags & ens))));

  a_r9_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags & ens) == '0) |=> !irq_o);
endmodule

bind evt_irq_sel evt_irq_sel_chk #(.N(N)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .event_i(event_i), .cfg_we_i(cfg_we_i),
  .clr_we_i(clr_we_i), .clr_wdata_i(clr_wdata_i), .set_we_i(set_we_i),
  .set_wdata_i(set_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
);

// File: tb/evt_irq_sel_tb.sv
module evt_irq_sel_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  event_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic        clr_we_i = 1'b0;
  logic [7:0]  clr_wdata_i = '0;
  logic        set_we_i = 1'b0;
  logic [7:0]  set_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        irq_o;

  int n_chk = 0, n_bad = 0;
  string tag = "R1";
  logic [7:0] m_fl = '0, m_en = '0;
  logic       m_irq = 1'b0;

  always #5 clk_i = ~clk_i;

  evt_irq_sel u_dut (.*);

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_fl <= '0; m_en <= '0; m_irq <= 1'b0;
    end else begin
      m_irq <= (m_fl & m_en) != 0;
      if (cfg_we_i) m_en <= cfg_wdata_i[15:8];
      m_fl <= (clr_we_i ? (m_fl & ~clr_wdata_i) : m_fl)
              | event_i | (set_we_i ? set_wdata_i : 8'h00);
    end
  end

  task automatic check(string r, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic compare();
    check({tag, " flags"}, {8'h00, reg_rdata_o[7:0]}, {8'h00, m_fl});
    check({tag, " enables"}, {8'h00, reg_rdata_o[15:8]}, {8'h00, m_en});
    check({tag, " irq"}, {15'h0, irq_o}, {15'h0, m_irq});
  endtask

  task automatic step(logic [7:0] ev, logic cw, logic [15:0] cd,
                      logic clw, logic [7:0] cld, logic sw, logic [7:0] sd);
    event_i = ev; cfg_we_i = cw; cfg_wdata_i = cd;
    clr_we_i = clw; clr_wdata_i = cld; set_we_i = sw; set_wdata_i = sd;
    @(negedge clk_i);
    compare();
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    tag = "R1";
    check("R1 reset read", reg_rdata_o, 16'h0000);
    check("R1 reset irq", {15'h0, irq_o}, 16'h0000);
    rst_ni = 1'b1;
    step(8'h00, 0, 0, 0, 0, 0, 0);
    tag = "R2";
    step(8'h05, 0, 0, 0, 0, 0, 0);
    check("R2 flags latched while masked", reg_rdata_o, 16'h0005);
    tag = "R9";
    step(8'h00, 0, 0, 0, 0, 0, 0);
    check("R9 masked no irq", {15'h0, irq_o}, 16'h0000);
    tag = "R6";
    step(8'h00, 1, 16'h04FF, 0, 0, 0, 0);
    check("R6 enable write keeps flags", reg_rdata_o, 16'h0405);
    tag = "R8";
    step(8'h00, 0, 0, 0, 0, 0, 0);
    check("R8 irq one cycle later", {15'h0, irq_o}, 16'h0001);
    tag = "R4";
    step(8'h00, 0, 0, 1, 8'h04, 0, 0);
    check("R4 w1c clears bit 2 only", reg_rdata_o, 16'h0401);
    step(8'h00, 0, 0, 0, 0, 0, 0);
    check("R4 irq drops after clear", {15'h0, irq_o}, 16'h0000);
    tag = "R5";
    step(8'h80, 0, 0, 1, 8'h81, 0, 0);
    check("R5 event beats clear", reg_rdata_o, 16'h0480);
    step(8'h00, 0, 0, 1, 8'h80, 1, 8'h80);
    check("R5 set beats clear", reg_rdata_o, 16'h0480);
    tag = "R7";
    step(8'h00, 0, 0, 0, 0, 1, 8'h30);
    check("R7 set port", reg_rdata_o, 16'h04B0);
    tag = "R3";
    repeat (5) step(8'h00, 0, 0, 0, 0, 0, 0);
    check("R3 flags sticky", reg_rdata_o, 16'h04B0);
    tag = "R8";
    for (int k = 0; k < 400; k++)
      step(8'($urandom) & 8'($urandom), ($urandom % 5) == 0, 16'($urandom),
           ($urandom % 3) == 0, 8'($urandom), ($urandom % 9) == 0, 8'($urandom));
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule